// File: doc/BRIEF.md
# Flash Write Status Readback

This block is the read path of a byte-wide flash device model. It sits between the array storage and the data bus. It decides what a read returns. In normal operation that is the array byte. While an internal program or erase is running, the byte is replaced by status bits that let a host poll for completion. While the device is in identification mode, reads at a few low addresses return fixed identity codes and the boot-area lock state.

The block also contains the operation timer. A start pulse loads a cycle count: one programmable count for byte program and another for erase. The busy flag stays high until the count runs out, and then the block falls back to normal reads by itself. The host reads status with the usual strobe. Bit 7 is a data-polling bit and bit 6 flips once per read access. Bits 5 to 0 carry the array byte.

Top module: `flash_status_rd`

## Requirements
- R1: While a program operation is busy, a read returns bit 7 as the inverse of bit 7 of the byte last written (`wr_last_data`).
- R2: While an erase operation is busy, bit 7 of a read is 0. Bits 5 to 0 of any busy read carry `arr_data[5:0]`.
- R3: While busy, bit 6 inverts once for each new read access, on the rising edge of `rd_en`. The first access after a start returns 1. Holding `rd_en` high keeps bit 6 unchanged. The toggle state returns to 0 whenever busy is low.
- R4: Once busy falls, reads return `arr_data` unchanged, for example FFh from an erased location, with no status bits.
- R5: In identification mode, with busy low, a read at address 0 returns DAh and a read at address 1 returns 0Bh. Every other address bit must be 0 for these codes.
- R6: In identification mode, with busy low, a read at address 2 returns `lock_flag` on bit 0, where 1 means locked, and 0 on bits 7 to 1.
- R7: Busy status takes priority over identification mode. Addresses other than 0, 1 and 2 in identification mode return `arr_data`.
- R8: A `start_op` pulse while idle sets busy at the next edge. Busy then stays high for exactly N cycles. N is `erase_cycles` when `op_erase` is 1 and `prog_cycles` otherwise, and a count of 0 acts as 1. A `start_op` while busy is ignored and changes neither the timing nor the operation type.
- R9: While `rst_n` is low, `dout_oe` is 0, `dout` is 0 and busy is 0. An operation in progress is abandoned.
- R10: `dout` and `dout_oe` are registered one edge after `rd_en`. When `rd_en` is low, `dout_oe` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| arr_data | input | 8 | Byte from array storage at rd_addr |
| start_op | input | 1 | Starts an internal operation |
| op_erase | input | 1 | Operation type at start: 1 erase, 0 program |
| wr_last_data | input | 8 | Last byte written by the host |
| id_mode | input | 1 | Identification mode active |
| lock_flag | input | 1 | Boot-area lockout state |
| prog_cycles | input | CW | Program duration in cycles |
| erase_cycles | input | CW | Erase duration in cycles |
| busy | output | 1 | Internal operation in progress |
| dout | output | 8 | Read data byte |
| dout_oe | output | 1 | Bus drive enable |

## Verification
Every read result is due on the first clock edge after the strobe is applied. The bench drives inputs on the falling edge and samples `dout` on the next falling edge, so exactly one register lies between stimulus and check. Busy rises on the edge that captures `start_op`. The bench counts the falling-edge samples on which busy is high and compares that count with the loaded N. Toggle checks drop the strobe for one cycle between reads, so each read is a fresh rising edge, except in the held-strobe check, where the strobe stays high across several samples.

// File: rtl/flash_status_rd.sv
module flash_status_rd #(
  parameter int AW        = 18,
  parameter int CW        = 16,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    arr_data,
  input  logic          start_op,
  input  logic          op_erase,
  input  logic [7:0]    wr_last_data,
  input  logic          id_mode,
  input  logic          lock_flag,
  input  logic [CW-1:0] prog_cycles,
  input  logic [CW-1:0] erase_cycles,
  output logic          busy,
  output logic [7:0]    dout,
  output logic          dout_oe
);

  localparam logic [AW-1:0] ADDR_MFR  = AW'(0);
  localparam logic [AW-1:0] ADDR_DEV  = AW'(1);
  localparam logic [AW-1:0] ADDR_LOCK = AW'(2);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_ld;
  logic          erase_q;
  logic          rd_q;
  logic          tgl;
  logic          tgl_nx;
  logic          rd_rise;
  logic [7:0]    d_nx;

  assign cnt_ld  = op_erase ? erase_cycles : prog_cycles;
  assign rd_rise = rd_en & ~rd_q;
  assign tgl_nx  = busy ? (rd_rise ? ~tgl : tgl) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      erase_q <= 1'b0;
    end else if (!busy) begin
      if (start_op) begin
        busy    <= 1'b1;
        cnt     <= (cnt_ld == '0) ? CNT_ONE : cnt_ld;
        erase_q <= op_erase;
      end
    end else if (cnt == CNT_ONE) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      tgl  <= tgl_nx;
    end
  end

  always_comb begin
    d_nx = arr_data;
    if (busy) begin
      d_nx[7] = erase_q ? 1'b0 : ~wr_last_data[7];
      d_nx[6] = tgl_nx;
    end else if (id_mode) begin
      if (rd_addr == ADDR_MFR)       d_nx = MFR_CODE;
      else if (rd_addr == ADDR_DEV)  d_nx = DEV_CODE;
      else if (rd_addr == ADDR_LOCK) d_nx = {7'b0, lock_flag};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= rd_en ? d_nx : 8'h00;
      dout_oe <= rd_en;
    end
  end

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_q && rd_en) |=> (dout[7] == ~$past(wr_last_data[7]))); // R1
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_q && rd_en) |=> (dout[7] == 1'b0)); // R2
  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rd_en && rd_q) |=> $stable(dout[6])); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_op) |=> !busy); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_op) |=> busy); // R8
  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dout_oe); // R10
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!dout_oe && dout == 8'h00)); // R10

endmodule

// File: tb/flash_status_rd_tb_top.sv
module flash_status_rd_tb_top;
  localparam int AW = 18;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, start_op = 0, op_erase = 0, id_mode = 0, lock_flag = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] arr_data = 8'h00, wr_last_data = 8'h00;
  logic [CW-1:0] prog_cycles = 16'd20, erase_cycles = 16'd30;
  logic busy, dout_oe;
  logic [7:0] dout;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_status_rd #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_data(arr_data), .start_op(start_op), .op_erase(op_erase),
    .wr_last_data(wr_last_data), .id_mode(id_mode), .lock_flag(lock_flag),
    .prog_cycles(prog_cycles), .erase_cycles(erase_cycles),
    .busy(busy), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a; rd_en = 1;
    @(negedge clk); v = dout;
    chk("R10 oe during read", 32'(dout_oe), 1);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic start(bit er);
    op_erase = er; start_op = 1;
    @(negedge clk); start_op = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R9 oe in reset", 32'(dout_oe), 0);
    chk("R9 dout in reset", 32'(dout), 0);
    chk("R9 busy in reset", 32'(busy), 0);
  endtask

  task automatic t_program_poll;
    logic [7:0] v;
    int n;
    arr_data = 8'hA5; wr_last_data = 8'h35;
    start(0);
    rd(0, v); chk("R1 R3 first read", 32'(v), 32'hE5);
    rd(0, v); chk("R3 second read", 32'(v), 32'hA5);
    rd(0, v); chk("R3 third read", 32'(v), 32'hE5);
    rd_en = 1;
    @(negedge clk); chk("R3 held a", 32'(dout[6]), 0);
    @(negedge clk); chk("R3 held b", 32'(dout[6]), 0);
    @(negedge clk); chk("R3 held c", 32'(dout[6]), 0);
    rd_en = 0; @(negedge clk);
    chk("R10 dout idle", 32'({dout_oe, dout}), 0);
    wait_idle(n);
    arr_data = 8'h5C;
    rd(0, v); chk("R4 true data after program", 32'(v), 32'h5C);
    wr_last_data = 8'hC3;
    start(0);
    rd(0, v); chk("R1 inverted high bit", 32'(v[7]), 0);
    wait_idle(n);
  endtask

  task automatic t_erase_poll;
    logic [7:0] v;
    int n;
    arr_data = 8'hFF; wr_last_data = 8'hFF;
    start(1);
    rd(5, v); chk("R2 R3 erase first read", 32'(v), 32'h7F);
    rd(5, v); chk("R2 erase second read", 32'(v), 32'h3F);
    wait_idle(n);
    rd(5, v); chk("R4 erased reads FF", 32'(v), 32'hFF);
  endtask

  task automatic t_timer;
    int n;
    prog_cycles = 16'd13; erase_cycles = 16'd27;
    start(0); wait_idle(n); chk("R8 program length", 32'(n), 13);
    @(negedge clk);
    start(1); wait_idle(n); chk("R8 erase length", 32'(n), 27);
    erase_cycles = 16'd0;
    start(1); wait_idle(n); chk("R8 zero count", 32'(n), 1);
    prog_cycles = 16'd20; erase_cycles = 16'd40;
    wr_last_data = 8'h00;
    start(0);
    repeat (4) @(negedge clk);
    start(1);
    begin
      logic [7:0] v;
      rd(0, v); chk("R8 restart ignored type", 32'(v[7]), 1);
    end
    wait_idle(n); chk("R8 restart ignored length", 32'(n), 20 - 7);
  endtask

  task automatic t_id;
    logic [7:0] v;
    int n;
    id_mode = 1; arr_data = 8'h77;
    rd(0, v); chk("R5 maker code", 32'(v), 32'hDA);
    rd(1, v); chk("R5 device code", 32'(v), 32'h0B);
    rd(18'h10001, v); chk("R5 high bits set", 32'(v), 32'h77);
    lock_flag = 1; rd(2, v); chk("R6 locked", 32'(v), 32'h01);
    lock_flag = 0; rd(2, v); chk("R6 unlocked", 32'(v), 32'h00);
    rd(3, v); chk("R7 other id address", 32'(v), 32'h77);
    wr_last_data = 8'h00; start(0);
    rd(0, v); chk("R7 busy over id", 32'(v), 32'hF7);
    wait_idle(n);
    id_mode = 0;
    rd(0, v); chk("R7 id off", 32'(v), 32'h77);
  endtask

  task automatic t_reset_mid;
    logic [7:0] v;
    start(1);
    repeat (3) @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk("R9 busy dropped", 32'(busy), 0);
    rst_n = 1; @(negedge clk);
    arr_data = 8'h9E;
    rd(0, v); chk("R9 normal after reset", 32'(v), 32'h9E);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; @(negedge clk);
    t_program_poll();
    t_erase_poll();
    t_timer();
    t_id();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule